// File: doc/BRIEF.md
# Scatter-gather table-walking DMA engine

This block moves a byte stream between a device-side buffer and host memory. Host memory is described by a table of 8-byte descriptors. Each descriptor names one contiguous buffer segment. After a start pulse the engine works on its own. It reads the table through the same request port that carries the data bursts, decodes each descriptor, and issues read or write bursts against the current segment. It stops when the table ends, which happens either at a descriptor flagged as last or at a fixed table span.

The request byte count and the table can disagree. If the table is longer than the request, the engine keeps reading descriptors to the end of the table but moves no more data. If the table is shorter, the engine finishes with a one-cycle short-table error pulse instead of the done pulse. The data payload of a burst travels on a path outside this block. The engine only issues the address, length and direction of each burst.

Top module: `prd_dma_engine`

## Requirements
- R1: A descriptor fetch is a request with `mem_req_desc`=1, `mem_req_len`=8 and the address of the table pointer. The pointer starts at `tbl_base` and moves forward by 8 after each fetch. In the response word, bits [31:0] hold the segment address and bits [63:32] hold the size word.
- R2: The segment byte count is size-word bits [15:0] with bit 0 forced to zero. Size-word bits [30:16] are ignored.
- R3: A masked byte count of zero means a 65536-byte segment.
- R4: Size-word bit 31 (response bit 63) marks the last descriptor. No fetch follows it; the walk ends once that segment is used up.
- R5: The walk also ends once the pointer is `TABLE_SPAN` (4096) bytes past `tbl_base`. With no last flag, this allows at most 512 fetches.
- R6: Each data burst is 1 to `MAX_BURST` (256) bytes. Its size is the smaller of the bytes left in the segment and the bytes left in the request. A burst never crosses a segment end. After each burst, the segment address advances by the burst size, so a transfer continues across descriptors.
- R7: When the table ends with no request bytes left, `done` pulses for one cycle. When request bytes remain, `short_err` pulses instead. The two never pulse together.
- R8: Descriptors beyond what the request needs are still fetched, but they produce no data bursts.
- R9: `mem_req_write` on data bursts equals the `to_mem` value captured at start: 1 writes host memory, 0 reads it.
- R10: Once raised, `mem_req_valid` and the request fields hold steady until the cycle in which `mem_req_ready` is high.
- R11: `start` is accepted only while `busy` is low. It reloads the pointer and clears the segment state. A start pulse during a run is ignored.
- R12: After reset, `busy`, `mem_req_valid`, `done` and `short_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, honoured only when idle |
| to_mem | input | 1 | 1: write host memory, 0: read host memory |
| tbl_base | input | 32 | Byte address of the descriptor table |
| xfer_len | input | LEN_W | Requested byte count |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: run completed |
| short_err | output | 1 | One-cycle pulse: table ended before the request was met |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_len | output | BURST_W | Request byte length |
| mem_req_write | output | 1 | Data burst is a write |
| mem_req_desc | output | 1 | Request is a descriptor fetch |
| mem_rsp_valid | input | 1 | Descriptor response valid |
| mem_rsp_data | input | 64 | Descriptor response, little-endian word pair |

## Verification
Two end-of-run conditions can occur in the same cycle. The request count can reach zero on the very burst that empties the last-flagged segment. The last flag can also sit on the descriptor that exactly reaches the 4 KiB table span. The bench provokes the first case with a single last-flagged segment whose size equals the request. It provokes the second with a full 512-entry table flagged last at its final slot and a request equal to the table total. In both cases it requires `done` rather than `short_err`, and the exact fetch count. A companion run with the same 512-entry table and no last flag must instead give `short_err` after exactly 512 fetches.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
  localparam int ADDR_W     = 32;
  localparam int SEG_W      = 17;
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STEP, ST_FREQ, ST_FWAIT, ST_BURST
  } prd_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [SEG_W-1:0]  len;
    logic              last;
  } prd_entry_t;
endpackage

// File: rtl/prd_desc_decode.sv
module prd_desc_decode
  import prd_dma_pkg::*;
(
  input  logic [63:0] raw,
  output prd_entry_t  ent
);
  logic [15:0] masked;

  always_comb begin
    masked   = raw[47:32] & 16'hFFFE;
    ent.addr = raw[31:0];
    ent.len  = (masked == 16'd0) ? 17'h10000 : {1'b0, masked};
    ent.last = raw[63];
  end
endmodule

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc #(
  parameter int LEN_W     = 20,
  parameter int MAX_BURST = 256,
  parameter int SEG_W     = 17,
  localparam int BURST_W  = $clog2(MAX_BURST) + 1,
  localparam int CMP_W    = (LEN_W > SEG_W) ? LEN_W : SEG_W
) (
  input  logic [SEG_W-1:0]   seg_left,
  input  logic [LEN_W-1:0]   req_left,
  output logic [BURST_W-1:0] chunk
);
  logic [CMP_W-1:0] s, r, m;

  always_comb begin
    s = CMP_W'(seg_left);
    r = CMP_W'(req_left);
    m = (s < r) ? s : r;
    if (m > CMP_W'(MAX_BURST)) m = CMP_W'(MAX_BURST);
    chunk = m[BURST_W-1:0];
  end
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
  import prd_dma_pkg::*;
#(
  parameter int LEN_W      = 20,
  parameter int MAX_BURST  = 256,
  parameter int TABLE_SPAN = 4096,
  localparam int BURST_W   = $clog2(MAX_BURST) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               to_mem,
  input  logic [31:0]        tbl_base,
  input  logic [LEN_W-1:0]   xfer_len,
  output logic               busy,
  output logic               done,
  output logic               short_err,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [31:0]        mem_req_addr,
  output logic [BURST_W-1:0] mem_req_len,
  output logic               mem_req_write,
  output logic               mem_req_desc,
  input  logic               mem_rsp_valid,
  input  logic [63:0]        mem_rsp_data
);
  prd_state_e        state_q;
  logic [ADDR_W-1:0] base_q, ptr_q, seg_addr_q, walked;
  logic [SEG_W-1:0]  seg_left_q;
  logic              seg_last_q, dir_q, table_end;
  logic [LEN_W-1:0]  req_left_q;
  prd_entry_t        fetched;
  logic [BURST_W-1:0] chunk;

  prd_desc_decode u_decode (.raw(mem_rsp_data), .ent(fetched));

  prd_chunk_calc #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .SEG_W(SEG_W)) u_chunk (
    .seg_left(seg_left_q), .req_left(req_left_q), .chunk(chunk)
  );

  assign walked    = ptr_q - base_q;
  assign table_end = seg_last_q || (walked >= ADDR_W'(TABLE_SPAN));
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      base_q        <= '0;
      ptr_q         <= '0;
      seg_addr_q    <= '0;
      seg_left_q    <= '0;
      seg_last_q    <= 1'b0;
      req_left_q    <= '0;
      dir_q         <= 1'b0;
      done          <= 1'b0;
      short_err     <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_len   <= '0;
      mem_req_write <= 1'b0;
      mem_req_desc  <= 1'b0;
    end else begin
      done      <= 1'b0;
      short_err <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            base_q     <= tbl_base;
            ptr_q      <= tbl_base;
            seg_addr_q <= '0;
            seg_left_q <= '0;
            seg_last_q <= 1'b0;
            req_left_q <= xfer_len;
            dir_q      <= to_mem;
            state_q    <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (seg_left_q == '0) begin
            if (table_end) begin
              done      <= (req_left_q == '0);
              short_err <= (req_left_q != '0);
              state_q   <= ST_IDLE;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= ptr_q;
              mem_req_len   <= BURST_W'(DESC_BYTES);
              mem_req_write <= 1'b0;
              mem_req_desc  <= 1'b1;
              state_q       <= ST_FREQ;
            end
          end else if (req_left_q == '0) begin
            seg_addr_q <= seg_addr_q + ADDR_W'(seg_left_q);
            seg_left_q <= '0;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= seg_addr_q;
            mem_req_len   <= chunk;
            mem_req_write <= dir_q;
            mem_req_desc  <= 1'b0;
            state_q       <= ST_BURST;
          end
        end
        ST_FREQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            ptr_q         <= ptr_q + ADDR_W'(DESC_BYTES);
            state_q       <= ST_FWAIT;
          end
        end
        ST_FWAIT: begin
          if (mem_rsp_valid) begin
            seg_addr_q <= fetched.addr;
            seg_left_q <= fetched.len;
            seg_last_q <= fetched.last;
            state_q    <= ST_STEP;
          end
        end
        ST_BURST: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            seg_addr_q    <= seg_addr_q + ADDR_W'(mem_req_len);
            seg_left_q    <= seg_left_q - SEG_W'(mem_req_len);
            req_left_q    <= req_left_q - LEN_W'(mem_req_len);
            state_q       <= ST_STEP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prd_dma_engine_chk.sv
module prd_dma_engine_chk #(
  parameter int MAX_BURST = 256,
  localparam int BURST_W  = $clog2(MAX_BURST) + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic               short_err,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [31:0]        mem_req_addr,
  input logic [BURST_W-1:0] mem_req_len,
  input logic               mem_req_desc
);
  // R6
  burst_len_range_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_desc) |-> (mem_req_len != '0 && mem_req_len <= BURST_W'(MAX_BURST)));

  // R1
  desc_fetch_len_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_desc) |-> (mem_req_len == BURST_W'(8)));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len) && $stable(mem_req_desc)));

  // R7
  end_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && short_err));

  // R7
  end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (done || short_err) |=> !(done || short_err));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);
endmodule

bind prd_dma_engine prd_dma_engine_chk #(.MAX_BURST(MAX_BURST)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .short_err(short_err),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len), .mem_req_desc(mem_req_desc)
);

// File: tb/prd_dma_engine_bench.sv
module prd_dma_engine_bench;
  localparam int LEN_W = 20;
  localparam int BW    = 9;
  localparam logic [31:0] TBASE = 32'h1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, to_mem = 1'b0;
  logic [31:0] tbl_base = TBASE;
  logic [LEN_W-1:0] xfer_len = '0;
  logic busy, done, short_err;
  logic mem_req_valid, mem_req_write, mem_req_desc;
  logic mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [BW-1:0] mem_req_len;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  prd_dma_engine #(.LEN_W(LEN_W)) u_prd_dma_engine (
    .clk(clk), .rst(rst), .start(start), .to_mem(to_mem), .tbl_base(tbl_base),
    .xfer_len(xfer_len), .busy(busy), .done(done), .short_err(short_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_req_write(mem_req_write), .mem_req_desc(mem_req_desc),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  logic [31:0] t_addr [512];
  logic [31:0] t_size [512];
  int cyc = 0;
  int fetch_cnt = 0, burst_cnt = 0;
  longint byte_cnt = 0;
  logic [31:0] b_addr [1024];
  int          b_len  [1024];
  logic        b_wr   [1024];
  int n_checks = 0, n_fail = 0;
  logic [31:0] off;

  // memory port model: stalling ready, one-cycle descriptor response
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 2;
    mem_rsp_valid <= 1'b0;
    if (!rst && mem_req_valid && mem_req_ready) begin
      if (mem_req_desc) begin
        off = mem_req_addr - TBASE;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= {t_size[off[11:3]], t_addr[off[11:3]]};
        fetch_cnt <= fetch_cnt + 1;
      end else begin
        b_addr[burst_cnt % 1024] <= mem_req_addr;
        b_len[burst_cnt % 1024]  <= int'(mem_req_len);
        b_wr[burst_cnt % 1024]   <= mem_req_write;
        burst_cnt <= burst_cnt + 1;
        byte_cnt  <= byte_cnt + longint'(mem_req_len);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < 512; i++) begin t_addr[i] = '0; t_size[i] = '0; end
  endtask

  int f0, b0, r_fetch, r_burst, r_done, r_err;
  longint y0, r_bytes;

  task automatic run(input logic [LEN_W-1:0] len, input logic dir, input bit poke);
    int waited = 0;
    @(negedge clk);
    f0 = fetch_cnt; b0 = burst_cnt; y0 = byte_cnt;
    tbl_base = TBASE; xfer_len = len; to_mem = dir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_done = 0; r_err = 0;
    forever begin
      if (poke && waited == 5) begin
        tbl_base = 32'h9000; xfer_len = 8; to_mem = ~dir; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      waited++;
      if (done || short_err) begin r_done = done; r_err = short_err; break; end
      if (waited > 30000) begin check(0, "run timeout", waited, 0); break; end
    end
    start = 1'b0; tbl_base = TBASE;
    @(negedge clk);
    r_fetch = fetch_cnt - f0; r_burst = burst_cnt - b0; r_bytes = byte_cnt - y0;
  endtask

  task automatic t_reset();
    check(!busy && !mem_req_valid && !done && !short_err, "R12 reset state",
          {busy, mem_req_valid, done, short_err}, 0);
  endtask

  task automatic t_single();
    clear_tbl();
    t_addr[0] = 32'h2000; t_size[0] = 32'h8000_0200;
    run(512, 1'b0, 1'b0);
    check(r_done == 1 && r_err == 0, "R7 done when request meets last segment", r_err, 0);
    check(r_fetch == 1, "R4 no fetch after last flag", r_fetch, 1);
    check(r_burst == 2, "R6 bursts capped at 256", r_burst, 2);
    check(b_addr[b0 % 1024] == 32'h2000 && b_addr[(b0+1) % 1024] == 32'h2100,
          "R6 address advances by chunk", b_addr[(b0+1) % 1024], 32'h2100);
    check(b_wr[b0 % 1024] == 1'b0, "R9 read direction", b_wr[b0 % 1024], 0);
  endtask

  task automatic t_cross();
    clear_tbl();
    t_addr[0] = 32'h3000; t_size[0] = 32'h7FFF_0065;   // bit0 and bits 30:16 ignored -> 100
    t_addr[1] = 32'h5000; t_size[1] = 32'h8000_0190;
    run(300, 1'b1, 1'b1);
    check(b_len[b0 % 1024] == 100, "R2 bit 0 and high bits masked", b_len[b0 % 1024], 100);
    check(b_addr[(b0+1) % 1024] == 32'h5000 && b_len[(b0+1) % 1024] == 200,
          "R6 transfer continues into next segment", b_len[(b0+1) % 1024], 200);
    check(r_burst == 2 && r_bytes == 300, "R6 total bytes", r_bytes, 300);
    check(b_wr[b0 % 1024] == 1'b1, "R9 write direction", b_wr[b0 % 1024], 1);
    check(r_fetch == 2 && r_done == 1, "R11 start during run ignored", r_fetch, 2);
    check(b_addr[b0 % 1024] == 32'h3000, "R1 first segment address from word [31:0]",
          b_addr[b0 % 1024], 32'h3000);
  endtask

  task automatic t_extra();
    clear_tbl();
    for (int i = 0; i < 3; i++) begin t_addr[i] = 32'h100 * (i + 1); t_size[i] = 32'd64; end
    t_size[2] = 32'h8000_0040;
    run(64, 1'b0, 1'b0);
    check(r_fetch == 3, "R8 extra descriptors still fetched", r_fetch, 3);
    check(r_burst == 1 && r_bytes == 64, "R8 no data for extra descriptors", r_bytes, 64);
    check(r_done == 1, "R8 done after walking table", r_done, 1);
  endtask

  task automatic t_short();
    clear_tbl();
    t_addr[0] = 32'h7000; t_size[0] = 32'h8000_0040;
    run(100, 1'b0, 1'b0);
    check(r_err == 1 && r_done == 0, "R7 short-table error", r_err, 1);
    check(r_bytes == 64, "R7 moved only table bytes", r_bytes, 64);
  endtask

  task automatic t_big();
    clear_tbl();
    t_addr[0] = 32'h0001_0000; t_size[0] = 32'h8000_0001;
    run(20'd65536, 1'b0, 1'b0);
    check(r_done == 1 && r_bytes == 65536, "R3 zero count means 65536", r_bytes, 65536);
    check(r_burst == 256, "R3 R6 burst count for 64 KiB", r_burst, 256);
    check(b_addr[(b0+255) % 1024] == 32'h0001_FF00, "R6 last burst address",
          b_addr[(b0+255) % 1024], 32'h0001_FF00);
  endtask

  task automatic t_span(input bit flag_end);
    clear_tbl();
    for (int i = 0; i < 512; i++) begin t_addr[i] = 32'h0010_0000 + 32'(i * 16); t_size[i] = 32'd2; end
    if (flag_end) t_size[511] = 32'h8000_0002;
    run(flag_end ? 20'd1024 : 20'd2000, 1'b1, 1'b0);
    check(r_fetch == 512, "R5 walk stops at 4 KiB span", r_fetch, 512);
    check(r_bytes == 1024, "R5 bytes moved within span", r_bytes, 1024);
    if (flag_end) check(r_done == 1 && r_err == 0, "R5 R7 last flag at span edge gives done", r_err, 0);
    else          check(r_err == 1 && r_done == 0, "R5 R7 span end with bytes left", r_done, 0);
  endtask

  task automatic t_fetch_addr();
    clear_tbl();
    t_addr[0] = 32'h400; t_size[0] = 32'd8;
    t_addr[1] = 32'h800; t_size[1] = 32'h8000_0008;
    run(16, 1'b0, 1'b0);
    check(r_fetch == 2 && b_addr[(b0+1) % 1024] == 32'h800, "R1 pointer advances by 8",
          b_addr[(b0+1) % 1024], 32'h800);
  endtask

  initial begin
    #1_500_000;
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    clear_tbl();
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_cross();
    t_extra();
    t_short();
    t_big();
    t_span(1'b0);
    t_span(1'b1);
    t_fetch_addr();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule